// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio using the pulse-swallow method. It has three parts. The first is a digital dual-modulus prescaler that divides by 64 or by 65. The second is a 6-bit swallow counter. The third is a 12-bit main counter. At the start of every output period the swallow counter holds the prescaler at 65 for A prescaler cycles. The prescaler then runs at 64 for the remaining N−A cycles. The main counter counts all N prescaler cycles and ends the period. Each output period therefore spans 64·N + A input cycles.

The output is a single-cycle comparison pulse, `fp_o`, that marks the end of each period. The block also exports the modulus-control level and a configuration-error flag. The ratio inputs are sampled only at a period boundary or when the divider starts from idle, so a period never mixes two ratios. An invalid ratio stops the divider and raises the error flag. The divider starts again by itself as soon as a valid ratio is presented.

Top module: `swallow_divider`

## Requirements
- R1: While running with a fixed valid ratio, consecutive `fp_o` pulses are exactly 64·N + A input cycles apart. A is `swal_a` and N is `main_n`, both read as unsigned binary.
- R2: `fp_o` is high for exactly one cycle per period.
- R3: In each period, `mc_o` (high means divide by 65) is high for exactly the first 65·A input cycles of the period, starting in the cycle that `fp_o` marks. `mc_o` never falls in a cycle where `fp_o` is high. With A = 0 it stays low.
- R4: Starting from idle, `fp_o` first goes high 64·N + A + 1 rising edges after the edge at which `en` is first sampled high together with a valid ratio. That edge counts as the first.
- R5: A ratio is invalid when N ≤ A or N < 5. If `en` is high in idle with an invalid ratio, `err_o` is high one edge later. While `err_o` stays high, `fp_o` and `mc_o` stay low. The divider restarts on its own once the ratio becomes valid.
- R6: Changes to `swal_a` and `main_n` during a period do not alter that period's length. They take effect in the following period.
- R7: If the ratio sampled at a period boundary is invalid, the pulse ending the finished period is still issued. `err_o` rises in that same cycle, and no further `fp_o` follows.
- R8: One edge after `en` is sampled low, `fp_o`, `mc_o` and `err_o` are all low. `err_o` stays low while `en` is low, even with an invalid ratio.
- R9: A synchronous active-high `rst` drives `fp_o`, `mc_o` and `err_o` low by the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Divider enable |
| swal_a | input | 6 | Swallow value A, unsigned binary |
| main_n | input | 12 | Main counter value N, unsigned binary |
| fp_o | output | 1 | One-cycle pulse at the end of each output period |
| mc_o | output | 1 | Modulus control: 1 selects divide-by-65, 0 selects divide-by-64 |
| err_o | output | 1 | Invalid-ratio flag |

## Verification
The two functions that can land in one cycle are the end-of-period pulse and error flagging. Both happen when the divider, at the boundary it has just reached, samples a ratio that has become invalid. The bench provokes this by running with a valid ratio and writing N = A partway through a period. It then requires that the period keeps its original length, that `fp_o` and `err_o` go high in the same sampled cycle, and that no pulse comes after it. A similar collision happens when `swal_a` and `main_n` change in mid-period. The bench checks that case by measuring the interrupted period and the following period separately.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  // Validity rule for a pulse-swallow ratio: main count above swallow count
  // and not below the minimum main count.
  function automatic logic ratio_ok(input int unsigned a, input int unsigned n,
                                    input int unsigned nmin);
    return (n > a) && (n >= nmin);
  endfunction
endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int PRE_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  input  logic mod_hi,
  output logic tick
);
  localparam int CW = PRE_LOG2 + 1;
  localparam logic [CW-1:0] LAST_LO = CW'((1 << PRE_LOG2) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(1 << PRE_LOG2);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == (mod_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] a_in,
  output logic         active
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt_q <= '0;
    else if (load)                  cnt_q <= a_in;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/pswd_main.sv
module pswd_main #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] n_in,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (load)   cnt_q <= n_in;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end

  assign wrap = tick && (cnt_q == W'(1));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int PRE_LOG2 = 6,
  parameter int N_W      = 12,
  parameter int N_MIN    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PRE_LOG2-1:0] swal_a,
  input  logic [N_W-1:0]      main_n,
  output logic                fp_o,
  output logic                mc_o,
  output logic                err_o
);
  import pswd_pkg::*;

  localparam int A_W = PRE_LOG2;

  logic run_q, run_d;
  logic ok_in, start, cont, load, clr;
  logic tick, wrap, mod_hi;
  logic fp_q, err_q;

  assign ok_in = ratio_ok(int'(swal_a), int'(main_n), N_MIN);
  assign start = !run_q && en && ok_in;
  assign cont  = run_q && en && wrap && ok_in;
  assign load  = start || cont;
  assign run_d = run_q ? (en && !(wrap && !ok_in)) : start;
  assign clr   = !run_d;

  pswd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .clr(clr), .mod_hi(mod_hi), .tick(tick)
  );

  pswd_swallow #(.W(A_W)) u_swl (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .tick(tick),
    .a_in(swal_a), .active(mod_hi)
  );

  pswd_main #(.W(N_W)) u_mn (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .tick(tick),
    .n_in(main_n), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      fp_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      fp_q  <= run_q && en && wrap;
      if (!en)                 err_q <= 1'b0;
      else if (!run_q || wrap) err_q <= !ok_in;
    end
  end

  assign fp_o  = fp_q;
  assign mc_o  = mod_hi;
  assign err_o = err_q;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int PRE_LOG2 = 6,
  parameter int N_MIN    = 5
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic fp_o,
  input logic mc_o,
  input logic err_o
);
  localparam int unsigned MIN_GAP = (1 << PRE_LOG2) * N_MIN;

  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      if (fp_o) gap_q <= 1;
      else if (gap_q < 32'h4000_0000) gap_q <= gap_q + 1;
      seen_q <= seen_q || fp_o;
    end
  end

  p_min_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (fp_o && seen_q && en) |-> (gap_q >= MIN_GAP));

  p_fp_single_r2: assert property (@(posedge clk) disable iff (rst)
    fp_o |=> !fp_o);

  p_mc_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mc_o) |-> !fp_o);

  p_err_mc_r5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !mc_o);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(err_o)) |-> !fp_o);

  p_en_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!fp_o && !mc_o && !err_o));
endmodule

bind swallow_divider swallow_divider_chk #(.PRE_LOG2(PRE_LOG2), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst(rst), .en(en), .fp_o(fp_o), .mc_o(mc_o), .err_o(err_o)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [17:0] VECS [NVEC] = '{
    {6'd0,  12'd5},
    {6'd4,  12'd5},
    {6'd3,  12'd7},
    {6'd0,  12'd6},
    {6'd63, 12'd64},
    {6'd10, 12'd12}
  };

  logic clk = 1'b0;
  logic rst, en;
  logic [5:0]  swal_a;
  logic [11:0] main_n;
  logic fp_o, mc_o, err_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .en(en), .swal_a(swal_a), .main_n(main_n),
    .fp_o(fp_o), .mc_o(mc_o), .err_o(err_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1: actual cycles=%0d expected below 150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // Count edges until fp is sampled high; mc high samples are counted from the
  // current sample up to the one before the pulse. Optional mid-wait change.
  task automatic next_fp(input int limit, input int chg, input logic [5:0] na,
                         input logic [11:0] nn, output int gap, output int mcs);
    gap = 0;
    mcs = int'(mc_o);
    forever begin
      step();
      gap++;
      if (gap == chg) begin swal_a = na; main_n = nn; end
      if (fp_o) break;
      mcs += int'(mc_o);
      if (gap >= limit) begin gap = -1; break; end
    end
  endtask

  task automatic go_idle();
    en = 1'b0;
    step(); step();
  endtask

  initial begin
    int g, m, p;
    rst = 1'b1; en = 1'b0; swal_a = '0; main_n = '0;
    repeat (3) step();
    chk(!fp_o && !mc_o && !err_o, "R9 reset state", {fp_o, mc_o, err_o}, 0);
    rst = 1'b0;
    step();

    for (int i = 0; i < NVEC; i++) begin
      logic [5:0]  va;
      logic [11:0] vn;
      {va, vn} = VECS[i];
      p = 64 * int'(vn) + int'(va);
      go_idle();
      swal_a = va; main_n = vn; en = 1'b1;
      next_fp(6000, -1, '0, '0, g, m);
      chk(g == p + 1, "R4 first pulse latency", g, p + 1);
      next_fp(6000, -1, '0, '0, g, m);
      chk(g == p, "R1 period length", g, p);
      chk(m == 65 * int'(va), "R3 mc high cycles", m, 65 * int'(va));
      step();
      chk(!fp_o, "R2 pulse width", int'(fp_o), 0);
    end

    // R5: invalid ratios from idle
    go_idle();
    swal_a = 6'd5; main_n = 12'd5; en = 1'b1;
    step();
    chk(err_o, "R5 err for N equal A", int'(err_o), 1);
    next_fp(800, -1, '0, '0, g, m);
    chk(g == -1 && m == 0 && err_o, "R5 quiet while N equal A", g, -1);
    swal_a = 6'd0; main_n = 12'd4;
    step();
    chk(err_o, "R5 err for N below 5", int'(err_o), 1);
    next_fp(800, -1, '0, '0, g, m);
    chk(g == -1 && m == 0, "R5 quiet while N below 5", g, -1);
    swal_a = 6'd0; main_n = 12'd5;
    next_fp(6000, -1, '0, '0, g, m);
    chk(g == 321, "R5 auto restart on valid ratio", g, 321);
    chk(!err_o, "R5 err cleared after restart", int'(err_o), 0);

    // R6: mid-period change
    go_idle();
    swal_a = 6'd2; main_n = 12'd6; en = 1'b1;
    next_fp(6000, -1, '0, '0, g, m);
    next_fp(6000, 50, 6'd0, 12'd5, g, m);
    chk(g == 386, "R6 period keeps old ratio", g, 386);
    chk(m == 130, "R6 mc of old ratio", m, 130);
    next_fp(6000, -1, '0, '0, g, m);
    chk(g == 320, "R6 new ratio next period", g, 320);
    chk(m == 0, "R3 mc stays low for A zero", m, 0);

    // R7: invalid ratio at a boundary
    go_idle();
    swal_a = 6'd1; main_n = 12'd5; en = 1'b1;
    next_fp(6000, -1, '0, '0, g, m);
    next_fp(6000, 100, 6'd5, 12'd5, g, m);
    chk(g == 321, "R7 finishing pulse issued", g, 321);
    chk(err_o, "R7 err with finishing pulse", int'(err_o), 1);
    next_fp(700, -1, '0, '0, g, m);
    chk(g == -1 && err_o && m == 0, "R7 no pulse after error", g, -1);

    // R8: enable drop while mc high
    go_idle();
    swal_a = 6'd3; main_n = 12'd5; en = 1'b1;
    repeat (10) step();
    chk(mc_o, "R3 mc high early in period", int'(mc_o), 1);
    en = 1'b0;
    step();
    chk(!fp_o && !mc_o && !err_o, "R8 outputs low after en drop", {fp_o, mc_o, err_o}, 0);
    swal_a = 6'd9; main_n = 12'd2;
    next_fp(500, -1, '0, '0, g, m);
    chk(g == -1 && !err_o, "R8 no err or pulse while disabled", g, -1);

    // R9: reset during running
    swal_a = 6'd3; main_n = 12'd5; en = 1'b1;
    repeat (20) step();
    rst = 1'b1;
    step();
    chk(!fp_o && !mc_o && !err_o, "R9 reset mid-run", {fp_o, mc_o, err_o}, 0);
    rst = 1'b0;
    next_fp(6000, -1, '0, '0, g, m);
    chk(g == 324, "R9 restart after reset", g, 324);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule